// File: doc/BRIEF.md
# PCI Bus Reset Sequencer

This block drives the active-low reset line of a PCI bus from two causes: the platform power-good input and a software hard-reset request. While power-good is low the bus reset is held asserted. Once power-good rises, the block counts bus clock cycles and releases the bus reset only after a programmable minimum hold time. At the nominal 33 MHz bus clock, 1 ms is about 33,000 cycles, which is the default. A smaller value can be set for fast runs.

Software asks for a hard reset by writing the reset-control register. This register sits at the I/O address given by `CTRL_ADDR`, which defaults to 0x0CF9. The write must have the hard-reset bit set, which is bit `HARD_BIT` and defaults to 2. The block then pulls the bus reset low for at least the same minimum time. A status output, `rst_active`, is high for the whole time the bus reset is asserted.

Power-good is brought into the clock domain with assertion that takes effect at once and release that is synchronized. Losing power-good therefore asserts the bus reset without waiting for a clock edge, and it restarts the whole power-up hold.

The sequencer has three states:

- `ST_PWR_HOLD` is the power-up hold.
- `ST_RUN` means the bus reset is released.
- `ST_SW_HOLD` is the software-requested hold.

Its transitions are:

- `T_PG_LOSS`: from any state to `ST_PWR_HOLD`, asynchronously, when power-good is lost.
- `T_PWR_DONE`: from `ST_PWR_HOLD` to `ST_RUN` when the hold timer expires.
- `T_SW_START`: from `ST_RUN` to `ST_SW_HOLD` on a qualifying register write.
- `T_SW_DONE`: from `ST_SW_HOLD` to `ST_RUN` when the hold timer expires.

Top module: `pcirs_seq`

## Requirements
- R1: While `pwr_good` is 0, `bus_rst_n` is 0 and `rst_active` is 1, with no clock edge needed after `pwr_good` falls.
- R2: Count clock edges from the first edge at which `pwr_good` is sampled high. `bus_rst_n` stays 0 through edge `SYNC_STAGES+MIN_CYCLES` and becomes 1 after edge `SYNC_STAGES+MIN_CYCLES+1`.
- R3: In `ST_RUN`, a write cycle (`io_wr`=1) with `io_addr`=`CTRL_ADDR` and `io_wdata` bit `HARD_BIT`=1 drives `bus_rst_n` to 0 at the clock edge that samples it. Other data bits do not matter.
- R4: The bus reset started at edge E by a software request is released after edge E+`MIN_CYCLES`+1. It is therefore low for `MIN_CYCLES`+1 cycles.
- R5: A write to `CTRL_ADDR` with bit `HARD_BIT`=0 has no effect on `bus_rst_n`.
- R6: A write to any other address, or a matching address and data presented with `io_wr`=0, has no effect.
- R7: Qualifying writes made during a software hold neither extend it nor restart it.
- R8: Qualifying writes made during the power-up hold are ignored. The release time is unchanged and no software hold follows.
- R9: A fall of `pwr_good` during the power-up hold, in `ST_RUN` or during a software hold asserts the bus reset at once. When `pwr_good` returns, the full power-up timing of R2 applies again.
- R10: `rst_active` is the inverse of `bus_rst_n` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock (nominally 33 MHz) |
| pwr_good | input | 1 | Platform power-good; low asserts bus reset asynchronously |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | ADDR_W (16) | I/O write address |
| io_wdata | input | DATA_W (8) | I/O write data |
| bus_rst_n | output | 1 | Active-low bus reset |
| rst_active | output | 1 | High while the bus reset is asserted |

## Verification
A wrong state or timer value shows up at `bus_rst_n` on the edge where the release should or should not happen. An off-by-one in the hold timer moves the rising edge by one cycle, and the bench catches this by sampling the edge just before the release and the edge at the release. A decode error in the write path shows up one edge after the write, as a reset that appears or is missing. A broken ignore rule during a hold shows up as a release that comes late. A power-good path that is synchronous instead of immediate leaves `bus_rst_n` high for a fraction of a cycle after `pwr_good` falls, and the bench checks for this before the next clock edge.

// File: rtl/pcirs_pkg.sv
package pcirs_pkg;

    // Sequencer states; the order is not decoded elsewhere.
    typedef enum logic [1:0] {
        ST_PWR_HOLD = 2'd0,
        ST_RUN      = 2'd1,
        ST_SW_HOLD  = 2'd2
    } seq_state_e;

    // Width for a counter that must reach a given limit value.
    function automatic int unsigned cnt_width(input int unsigned limit);
        int unsigned w;
        w = $clog2(limit + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/pcirs_pg_sync.sv
// Power-good conditioner: immediate assertion, synchronized release.
module pcirs_pg_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic pwr_good,
    output logic pg_sync
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= 1'b1;
            for (int i = 1; i < int'(STAGES); i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign pg_sync = chain_q[STAGES-1];

    AST_SYNC_RISE_ORDERED: assert property (@(posedge clk) disable iff (!pwr_good)
        $rose(pg_sync) |-> $past(chain_q[0])); // R2

endmodule

// File: rtl/pcirs_wr_decode.sv
// Recognizes a hard-reset request on the I/O write port.
module pcirs_wr_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0CF9,
    parameter int unsigned HARD_BIT  = 2
) (
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              sw_hit
);

    localparam logic [DATA_W-1:0] HARD_MASK = DATA_W'(1) << HARD_BIT;

    logic addr_match;
    logic bit_set;

    always_comb begin
        addr_match = (io_addr == CTRL_ADDR);
        bit_set    = ((io_wdata & HARD_MASK) != '0);
        sw_hit     = io_wr && addr_match && bit_set;
    end

endmodule

// File: rtl/pcirs_hold_timer.sv
// Minimum-hold counter: counts enabled cycles up to LIMIT and holds.
module pcirs_hold_timer #(
    parameter int unsigned LIMIT = 33000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);

    localparam int unsigned CW = pcirs_pkg::cnt_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = (cnt_q == LAST);

    AST_TIMER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R4
    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !done) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
    AST_TIMER_HOLDS_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> done); // R4

endmodule

// File: rtl/pcirs_seq.sv
// Bus reset sequencer top.
module pcirs_seq
    import pcirs_pkg::*;
#(
    parameter int unsigned MIN_CYCLES  = 33000,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned DATA_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0CF9,
    parameter int unsigned HARD_BIT    = 2
) (
    input  logic              clk,
    input  logic              pwr_good,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic              bus_rst_n,
    output logic              rst_active
);

    logic       pg_s;
    logic       sw_hit;
    logic       tmr_done;
    logic       tmr_clr;
    logic       tmr_en;
    seq_state_e state_q;
    seq_state_e state_d;

    pcirs_pg_sync #(
        .STAGES (SYNC_STAGES)
    ) u_pg_sync (
        .clk      (clk),
        .pwr_good (pwr_good),
        .pg_sync  (pg_s)
    );

    pcirs_wr_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CTRL_ADDR (CTRL_ADDR),
        .HARD_BIT  (HARD_BIT)
    ) u_wr_decode (
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_wdata (io_wdata),
        .sw_hit   (sw_hit)
    );

    pcirs_hold_timer #(
        .LIMIT (MIN_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (pg_s),
        .clr   (tmr_clr),
        .en    (tmr_en),
        .done  (tmr_done)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWR_HOLD: if (tmr_done) state_d = ST_RUN;      // T_PWR_DONE
            ST_RUN:      if (sw_hit)   state_d = ST_SW_HOLD;  // T_SW_START
            ST_SW_HOLD:  if (tmr_done) state_d = ST_RUN;      // T_SW_DONE
            default:                   state_d = ST_PWR_HOLD;
        endcase
    end

    // State register; loss of power-good is T_PG_LOSS.
    always_ff @(posedge clk or negedge pg_s) begin
        if (!pg_s) begin
            state_q <= ST_PWR_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and timer control.
    always_comb begin
        bus_rst_n  = (state_q == ST_RUN);
        rst_active = (state_q != ST_RUN);
        tmr_en     = (state_q != ST_RUN);
        tmr_clr    = (state_q == ST_RUN);
    end

    AST_SW_ENTRY: assert property (@(posedge clk) disable iff (!pg_s)
        (state_q == ST_RUN && sw_hit) |=> (state_q == ST_SW_HOLD)); // R3
    AST_RELEASE_AFTER_COUNT: assert property (@(posedge clk) disable iff (!pg_s)
        $rose(bus_rst_n) |-> $past(tmr_done)); // R4
    AST_NO_SPURIOUS_RESET: assert property (@(posedge clk) disable iff (!pg_s)
        (state_q == ST_RUN && !sw_hit) |=> (state_q == ST_RUN)); // R5
    AST_SW_HOLD_NOT_EXTENDED: assert property (@(posedge clk) disable iff (!pg_s)
        (state_q == ST_SW_HOLD && tmr_done) |=> (state_q == ST_RUN)); // R7
    AST_PWR_HOLD_NO_SW: assert property (@(posedge clk) disable iff (!pg_s)
        (state_q == ST_PWR_HOLD) |=> (state_q != ST_SW_HOLD)); // R8

endmodule

// File: tb/pcirs_seq_tb.sv
module pcirs_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NMIN       = 8;
    localparam int NSYNC      = 2;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  data;
        logic        fires;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{wr:1'b1, addr:16'h0CF9, data:8'h04, fires:1'b1},
        '{wr:1'b1, addr:16'h0CF9, data:8'h02, fires:1'b0},
        '{wr:1'b1, addr:16'h0CF9, data:8'h0E, fires:1'b1},
        '{wr:1'b1, addr:16'h0CF8, data:8'h04, fires:1'b0},
        '{wr:1'b1, addr:16'h0CF9, data:8'hFB, fires:1'b0},
        '{wr:1'b0, addr:16'h0CF9, data:8'h04, fires:1'b0},
        '{wr:1'b1, addr:16'h0CF9, data:8'hFF, fires:1'b1},
        '{wr:1'b1, addr:16'h1CF9, data:8'hFF, fires:1'b0}
    };

    logic        clk = 1'b0;
    logic        pwr_good = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        bus_rst_n;
    logic        rst_active;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcirs_seq #(
        .MIN_CYCLES  (NMIN),
        .SYNC_STAGES (NSYNC)
    ) u_dut (
        .clk        (clk),
        .pwr_good   (pwr_good),
        .io_wr      (io_wr),
        .io_addr    (io_addr),
        .io_wdata   (io_wdata),
        .bus_rst_n  (bus_rst_n),
        .rst_active (rst_active)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input logic got, input logic exp, input string tag);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // Raise power-good at a negedge and check the release timing.
    task automatic power_up(input string tag);
        pwr_good = 1'b1;
        step(NSYNC + NMIN);
        check(bus_rst_n, 1'b0, {tag, " hold before release"});
        check(rst_active, 1'b1, "R10 active during hold");
        step(1);
        check(bus_rst_n, 1'b1, {tag, " release edge"});
        check(rst_active, 1'b0, "R10 inactive after release");
    endtask

    task automatic put_write(input logic wr, input logic [15:0] a, input logic [7:0] d);
        io_wr = wr; io_addr = a; io_wdata = d;
        step(1);
        io_wr = 1'b0; io_addr = '0; io_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset state with power-good low
        step(3);
        check(bus_rst_n, 1'b0, "R1 low while power-good low");
        check(rst_active, 1'b1, "R1 active while power-good low");

        // R2: power-up timing
        power_up("R2");

        // R3 R4 R5 R6: vector table
        for (int v = 0; v < NVEC; v++) begin
            put_write(VECS[v].wr, VECS[v].addr, VECS[v].data);
            if (VECS[v].fires) begin
                check(bus_rst_n, 1'b0, "R3 software reset asserted");
                step(NMIN);
                check(bus_rst_n, 1'b0, "R4 held through minimum");
                step(1);
                check(bus_rst_n, 1'b1, "R4 released after minimum");
            end else begin
                check(bus_rst_n, 1'b1, "R5/R6 write ignored");
                step(3);
                check(bus_rst_n, 1'b1, "R5 R6 no late reset");
            end
        end

        // R7: writes during software hold do not extend it
        put_write(1'b1, 16'h0CF9, 8'h04);
        step(3);
        put_write(1'b1, 16'h0CF9, 8'h04);
        step(NMIN - 4);
        check(bus_rst_n, 1'b0, "R7 still held");
        step(1);
        check(bus_rst_n, 1'b1, "R7 release not extended");
        step(4);
        check(bus_rst_n, 1'b1, "R7 no restart");

        // R9: power-good loss in run state
        pwr_good = 1'b0;
        #1;
        check(bus_rst_n, 1'b0, "R9 immediate in run");
        check(rst_active, 1'b1, "R1 active after loss");
        @(negedge clk);
        step(2);

        // R8: write during power-up hold ignored
        pwr_good = 1'b1;
        step(3);
        put_write(1'b1, 16'h0CF9, 8'h04);
        step(NSYNC + NMIN - 4);
        check(bus_rst_n, 1'b0, "R8 hold before release");
        step(1);
        check(bus_rst_n, 1'b1, "R8 release unchanged");
        step(NMIN + 2);
        check(bus_rst_n, 1'b1, "R8 no software hold afterwards");

        // R9: loss during software hold, then full power-up
        put_write(1'b1, 16'h0CF9, 8'h04);
        step(2);
        pwr_good = 1'b0;
        #1;
        check(bus_rst_n, 1'b0, "R9 low in software hold");
        @(negedge clk);
        step(1);
        power_up("R9 restart after software hold");

        // R9: loss during power-up hold restarts the count
        pwr_good = 1'b0;
        #1;
        check(bus_rst_n, 1'b0, "R9 immediate");
        @(negedge clk);
        pwr_good = 1'b1;
        step(NMIN - 2);
        pwr_good = 1'b0;
        @(negedge clk);
        power_up("R9 restart during power-up hold");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule